// File: doc/BRIEF.md
# Signed and Unsigned Array Multiplier

This block multiplies two WIDTH-bit operands and returns their full 2·WIDTH-bit product with no clock and no state. A single mode input chooses whether the operands are read as unsigned binary or as two's-complement values. The arithmetic core is always an unsigned array. Each row is the multiplicand magnitude gated by one bit of the multiplier magnitude and shifted left by that bit's position. The rows are summed into the product.

For signed work, a small control stage looks at each operand's top bit and notes which operands are negative. The datapath turns each negative operand into its magnitude and feeds the magnitudes to the unsigned array. It then negates the array result when exactly one operand was negative. The magnitude path keeps the full operand width, so the most negative code still converts to a correct positive magnitude. A product with a zero operand is never negated, so it stays all zeros.

Top module: `smArrayMul`

## Requirements
- R1: With signedMode low, product equals the unsigned product of opA and opB; for WIDTH=4, 1011 × 1110 gives 10011010.
- R2: With signedMode high, product equals the two's-complement product of opA and opB; for WIDTH=4, 1011 (-5) × 0011 (+3) gives 11110001 (-15).
- R3: In signed mode the most negative operand (1000 for WIDTH=4, i.e. -8) converts to magnitude +8 without loss: -8 × -8 gives 01000000 and -8 × +1 gives 11111000.
- R4: When either operand is zero, product is all zeros in both modes, including -8 × 0 in signed mode.
- R5: In signed mode, product bit 2·WIDTH-1 is set exactly when both operands are non-zero and their top bits (bit WIDTH-1) differ.
- R6: In unsigned mode an operand top bit never causes negation: for WIDTH=4, 1000 × 1000 gives 01000000 and 1111 × 1111 gives 11100001.
- R7: The block is purely combinational: product reflects a change of opA, opB or signedMode within the same cycle, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | Multiplicand |
| opB | input | WIDTH | Multiplier |
| signedMode | input | 1 | 1: two's-complement operands, 0: unsigned operands |
| product | output | 2*WIDTH | Full-width product |

## Verification
Two functions can act on one operand pair in the same evaluation: magnitude conversion of the most negative code, and the decision whether to negate the result. They meet when -8 is multiplied by another negative value, by a positive value, or by zero. Every such pair is applied in both modes. The bench compares each result with a product computed from the operand values themselves. A zero operand paired with -8 checks that the negate decision does not corrupt an all-zero result.

// File: rtl/mulPkg.sv
package mulPkg;
  typedef struct packed {
    logic negA;     // opA is negative, convert to magnitude
    logic negB;     // opB is negative, convert to magnitude
    logic negProd;  // negate the unsigned array result
  } signCtrl_t;
endpackage

// File: rtl/signCtrl.sv
module signCtrl
  import mulPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             signedMode,
  output signCtrl_t        ctrl
);
  logic aNonZero;
  logic bNonZero;

  always_comb begin
    aNonZero     = |opA;
    bNonZero     = |opB;
    ctrl.negA    = signedMode & opA[WIDTH-1];
    ctrl.negB    = signedMode & opB[WIDTH-1];
    ctrl.negProd = (ctrl.negA ^ ctrl.negB) & aNonZero & bNonZero;
  end

  always_comb begin
    AST_UNSIGNED_NO_NEG: assert (signedMode || (ctrl == '0))
      else $error("negation strobe raised in unsigned mode"); // R6
    AST_NEG_FROM_MSB: assert (!ctrl.negA || opA[WIDTH-1])
      else $error("negA without a set sign bit"); // R2
  end
endmodule

// File: rtl/arrayCore.sv
module arrayCore #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]   magA,
  input  logic [WIDTH-1:0]   magB,
  output logic [2*WIDTH-1:0] rawProd
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] rowSum [0:WIDTH];

  assign rowSum[0] = '0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_row
    logic [WIDTH-1:0] partial;
    logic [PW-1:0]    shifted;
    assign partial      = magA & {WIDTH{magB[i]}};
    assign shifted      = {{WIDTH{1'b0}}, partial} << i;
    assign rowSum[i+1]  = rowSum[i] + shifted;
  end

  assign rawProd = rowSum[WIDTH];
endmodule

// File: rtl/magDatapath.sv
module magDatapath
  import mulPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  signCtrl_t          ctrl,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] magA;
  logic [WIDTH-1:0] magB;
  logic [PW-1:0]    rawProd;

  always_comb begin
    magA = ctrl.negA ? (~opA + 1'b1) : opA;
    magB = ctrl.negB ? (~opB + 1'b1) : opB;
  end

  arrayCore #(.WIDTH(WIDTH)) u_array (
    .magA    (magA),
    .magB    (magB),
    .rawProd (rawProd)
  );

  always_comb begin
    product = ctrl.negProd ? (~rawProd + 1'b1) : rawProd;
  end

  always_comb begin
    AST_ZERO_PRODUCT: assert (!((opA == '0) || (opB == '0)) || (product == '0))
      else $error("zero operand gave non-zero product"); // R4
    AST_PRODUCT_LSB: assert (product[0] == (opA[0] & opB[0]))
      else $error("product LSB mismatch"); // R1
    AST_MAG_MOST_NEG: assert (!ctrl.negA || (magA[WIDTH-1] == (opA[WIDTH-2:0] == '0)))
      else $error("magnitude of negative operand out of range"); // R3
  end
endmodule

// File: rtl/smArrayMul.sv
module smArrayMul
  import mulPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic               signedMode,
  output logic [2*WIDTH-1:0] product
);
  signCtrl_t ctrl;

  signCtrl #(.WIDTH(WIDTH)) u_ctrl (
    .opA        (opA),
    .opB        (opB),
    .signedMode (signedMode),
    .ctrl       (ctrl)
  );

  magDatapath #(.WIDTH(WIDTH)) u_data (
    .opA     (opA),
    .opB     (opB),
    .ctrl    (ctrl),
    .product (product)
  );
endmodule

// File: tb/smArrayMul_tb.sv
module smArrayMul_tb;
  localparam int W          = 4;
  localparam int PW         = 2 * W;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [W-1:0]  a;
    logic [W-1:0]  b;
    logic          m;
    logic [PW-1:0] exp;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  opA = '0;
  logic [W-1:0]  opB = '0;
  logic          signedMode = 1'b0;
  logic [PW-1:0] product;

  item_t sbQueue[$];
  int    nChecks = 0;
  int    nFails  = 0;
  bit    driverDone = 1'b0;
  bit    finished   = 1'b0;

  smArrayMul #(.WIDTH(W)) u_dut (
    .opA        (opA),
    .opB        (opB),
    .signedMode (signedMode),
    .product    (product)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [PW-1:0] refProd(logic [W-1:0] a, logic [W-1:0] b, logic m);
    int va;
    int vb;
    va = m ? int'($signed(a)) : int'(a);
    vb = m ? int'($signed(b)) : int'(b);
    return PW'(va * vb);
  endfunction

  task automatic check(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // driver: applies a pair and pushes its expected product
  task automatic pushItem(logic [W-1:0] a, logic [W-1:0] b, logic m,
                          logic [PW-1:0] exp, string tag);
    item_t it;
    @(posedge clk);
    opA = a; opB = b; signedMode = m;
    it.a = a; it.b = b; it.m = m; it.exp = exp; it.tag = tag;
    sbQueue.push_back(it);
  endtask

  // monitor: compares away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbQueue.size() > 0) begin
        item_t it;
        it = sbQueue.pop_front();
        check($sformatf("%s a=%b b=%b m=%0d", it.tag, it.a, it.b, it.m), product, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R4 reset state zero inputs", product, '0);

    // directed cases
    pushItem(4'b1011, 4'b1110, 1'b0, 8'b10011010, "R1 directed");
    pushItem(4'b1011, 4'b0011, 1'b1, 8'b11110001, "R2 directed");
    pushItem(4'b1000, 4'b1000, 1'b1, 8'b01000000, "R3 most-neg squared");
    pushItem(4'b1000, 4'b0001, 1'b1, 8'b11111000, "R3 most-neg times one");
    pushItem(4'b1000, 4'b0000, 1'b1, 8'b00000000, "R4 most-neg times zero");
    pushItem(4'b0000, 4'b1111, 1'b1, 8'b00000000, "R4 zero times minus one");
    pushItem(4'b1000, 4'b1000, 1'b0, 8'b01000000, "R6 unsigned msb");
    pushItem(4'b1111, 4'b1111, 1'b0, 8'b11100001, "R6 unsigned all ones");

    // exhaustive sweep in both modes
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          pushItem(W'(a), W'(b), 1'(m), refProd(W'(a), W'(b), 1'(m)),
                   (m == 1) ? "R2 sweep" : "R1 sweep");
        end
      end
    end
    while (sbQueue.size() > 0) @(posedge clk);
    @(negedge clk);

    // R5: sign bit of signed results
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        logic expSign;
        opA = W'(a); opB = W'(b); signedMode = 1'b1;
        #1;
        expSign = (a != 0) && (b != 0) && (opA[W-1] != opB[W-1]);
        check($sformatf("R5 sign a=%0d b=%0d", a, b), {7'b0, product[PW-1]}, {7'b0, expSign});
      end
    end

    // R7: product follows inputs between clock edges
    @(negedge clk);
    opA = 4'b0111; opB = 4'b0111; signedMode = 1'b1;
    #1;
    check("R7 settle no edge", product, 8'd49);
    signedMode = 1'b0; opA = 4'b1001; opB = 4'b0011;
    #1;
    check("R7 mode flip no edge", product, 8'd27);
    signedMode = 1'b1;
    #1;
    check("R7 mode flip signed", product, 8'b11101011);

    driverDone = 1'b1;
    finishRun();
  end
endmodule